// File: doc/BRIEF.md
# Path Multicast Header Forwarding Unit

This unit sits in each router of a two-dimensional mesh and handles the header of a path-based multicast message. A header carries a bitmap with one bit per node and the identifier of the node that started the message. At the router where the message begins, the unit breaks the bitmap into four destination regions. The regions are chosen relative to the source's position, and the unit sends out one copy of the header for every region that holds a destination. Each copy follows a chain through its region's destinations, one after another, in sorted address order.

At every router along a chain, the unit checks whether its own node is in the bitmap. If it is, the unit pulses a delivery strobe to the local port and clears its own bit before the header moves on. Once no destinations remain, the copy ends at that router. If destinations remain, the unit picks an output direction toward the next destination in the chain using column-first, then row, routing. Copies leave through a single output channel with a valid/ready handshake, which carries a direction code. Node address is row times the column count plus column.

Top module: `mpf_hdr_fwd`

## Requirements
- R1: While reset is asserted and right after it is released, in_ready is 1, fwd_valid is 0 and dlv_valid is 0.
- R2: A transit header (in_inject=0) whose bitmap has bit local_id set raises dlv_valid for exactly one cycle, in the cycle after it is accepted. In that cycle dlv_src equals the header's in_src.
- R3: A transit header produces at most one copy. Its fwd_dests equals in_dests with bit local_id cleared, and its fwd_src equals in_src.
- R4: When nothing remains in a transit bitmap after the local bit is cleared (including an empty bitmap), no copy is sent. The unit returns to in_ready=1 and fwd_valid=0.
- R5: An injected header (in_inject=1, legal only where local_id equals in_src) gives no delivery strobe and drops the source's own bit. The remaining addresses fall into four regions: region 0 is address > source with column >= source column; region 1 is address > source with column < source column; region 2 is address < source with column >= source column; region 3 is address < source with column < source column. Exactly one copy is sent per non-empty region, in region order 0, 1, 2, 3, and each copy's fwd_dests is that region's set.
- R6: fwd_desc is 0 (ascending) for copies of regions 0 and 1 and 1 (descending) for regions 2 and 3. On a transit copy it equals the in_desc of the accepted header.
- R7: The next destination is the lowest set address in fwd_dests when fwd_desc=0 and the highest when fwd_desc=1. fwd_port is 0 (east) if its column is above local_id's column, 1 (west) if below, and otherwise 2 (south) if its row is above local_id's row, 3 (north) if below.
- R8: While fwd_valid=1 and fwd_ready=0, fwd_valid, fwd_dests, fwd_port, fwd_desc and fwd_src hold their values. Each accepted handshake consumes exactly one copy.
- R9: in_ready is 0 while any copy is pending or the delivery strobe is high. A header offered in that time is not taken and does not change the copies or strobes that follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| local_id | input | 6 | Address of this router's node, held constant while the unit is busy |
| in_valid | input | 1 | Header offered |
| in_ready | output | 1 | Unit can take a header |
| in_inject | input | 1 | 1: header starts here and is split into regions; 0: header in transit |
| in_desc | input | 1 | Order flag of a transit header (1 = descending) |
| in_src | input | 6 | Source node address |
| in_dests | input | 64 | Destination bitmap, bit i = node i |
| dlv_valid | output | 1 | One-cycle strobe: copy delivered to the local port |
| dlv_src | output | 6 | Source address of the delivered message |
| fwd_valid | output | 1 | Forwarded header copy available |
| fwd_ready | input | 1 | Downstream takes the copy |
| fwd_port | output | 2 | Output direction: 0 east, 1 west, 2 south, 3 north |
| fwd_desc | output | 1 | Order flag of the copy |
| fwd_src | output | 6 | Source address carried by the copy |
| fwd_dests | output | 64 | Remaining destination bitmap of the copy |

## Verification
The checker watches, on every cycle, that the delivery strobe is a single-cycle pulse and that a stalled copy holds all its fields. It also checks that a forwarded bitmap never contains the local node, never is empty, and never appears while a new header could be taken. Only the bench's scenarios can show that the region split is correct and that copies come out in region order with the right order flag. The same holds for the chosen output direction matching the first destination in the chain, and for a header offered while busy being left alone.

// File: rtl/mpf_pkg.sv
package mpf_pkg;
  typedef enum logic [1:0] {
    PORT_EAST  = 2'd0,
    PORT_WEST  = 2'd1,
    PORT_SOUTH = 2'd2,
    PORT_NORTH = 2'd3
  } port_e;

  localparam int NUM_REGIONS = 4;
  localparam int REG_W       = 2;
endpackage

// File: rtl/mpf_region_split.sv
module mpf_region_split #(
  parameter int COLS = 8,
  parameter int N    = 64,
  parameter int ID_W = 6
) (
  input  logic [ID_W-1:0]                             src,
  input  logic [N-1:0]                                dests,
  output logic [mpf_pkg::NUM_REGIONS-1:0][N-1:0]      region_mask
);
  logic [ID_W-1:0] src_col;
  assign src_col = src % ID_W'(COLS);

  for (genvar i = 0; i < N; i++) begin : g_node
    localparam logic [ID_W-1:0] ADDR = ID_W'(i);
    localparam logic [ID_W-1:0] COL  = ID_W'(i % COLS);
    logic above, right, self;
    assign above = (ADDR > src);
    assign right = (COL >= src_col);
    assign self  = (ADDR == src);
    // ascending half
    assign region_mask[0][i] = dests[i] &  above &  right;
    assign region_mask[1][i] = dests[i] &  above & ~right;
    // descending half, the source itself is excluded
    assign region_mask[2][i] = dests[i] & ~above &  right & ~self;
    assign region_mask[3][i] = dests[i] & ~above & ~right;
  end
endmodule

// File: rtl/mpf_next_hop.sv
module mpf_next_hop #(
  parameter int COLS = 8,
  parameter int N    = 64,
  parameter int ID_W = 6
) (
  input  logic [N-1:0]    mask,
  input  logic            desc,
  input  logic [ID_W-1:0] here,
  output mpf_pkg::port_e  port
);
  logic [ID_W-1:0] lo_idx, hi_idx, target;
  logic [ID_W-1:0] t_col, t_row, h_col, h_row;

  always_comb begin
    lo_idx = '0;
    hi_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask[i]) lo_idx = ID_W'(i);
    end
    for (int i = 0; i < N; i++) begin
      if (mask[i]) hi_idx = ID_W'(i);
    end
  end

  assign target = desc ? hi_idx : lo_idx;
  assign t_col  = target % ID_W'(COLS);
  assign t_row  = target / ID_W'(COLS);
  assign h_col  = here % ID_W'(COLS);
  assign h_row  = here / ID_W'(COLS);

  always_comb begin
    if (t_col > h_col)      port = mpf_pkg::PORT_EAST;
    else if (t_col < h_col) port = mpf_pkg::PORT_WEST;
    else if (t_row > h_row) port = mpf_pkg::PORT_SOUTH;
    else                    port = mpf_pkg::PORT_NORTH;
  end
endmodule

// File: rtl/mpf_hdr_fwd.sv
module mpf_hdr_fwd #(
  parameter  int ROWS = 8,
  parameter  int COLS = 8,
  localparam int N    = ROWS * COLS,
  localparam int ID_W = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ID_W-1:0] local_id,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic            in_inject,
  input  logic            in_desc,
  input  logic [ID_W-1:0] in_src,
  input  logic [N-1:0]    in_dests,
  output logic            dlv_valid,
  output logic [ID_W-1:0] dlv_src,
  output logic            fwd_valid,
  input  logic            fwd_ready,
  output logic [1:0]      fwd_port,
  output logic            fwd_desc,
  output logic [ID_W-1:0] fwd_src,
  output logic [N-1:0]    fwd_dests
);
  import mpf_pkg::*;

  localparam logic [N-1:0] ONE_N = {{(N-1){1'b0}}, 1'b1};

  // held header state
  logic [N-1:0]    pend_q, pend_d;
  logic [ID_W-1:0] src_q;
  logic            inj_q, desc_q;
  logic            dlv_q, dlv_d;
  logic            pend_en, meta_en;

  logic            accept, fire, busy;
  logic [N-1:0]    local_oh, src_oh;
  logic [NUM_REGIONS-1:0][N-1:0] region_mask;
  logic [REG_W-1:0] sel;
  logic [N-1:0]    copy_mask;
  logic            copy_desc;
  port_e           hop_port;

  assign local_oh = ONE_N << local_id;
  assign src_oh   = ONE_N << in_src;

  assign busy     = |pend_q;
  assign in_ready = ~busy & ~dlv_q;
  assign accept   = in_valid & in_ready;
  assign fire     = fwd_valid & fwd_ready;

  mpf_region_split #(.COLS(COLS), .N(N), .ID_W(ID_W)) u_split (
    .src         (src_q),
    .dests       (pend_q),
    .region_mask (region_mask)
  );

  // first non-empty region wins
  always_comb begin
    sel = '0;
    for (int r = NUM_REGIONS - 1; r >= 0; r--) begin
      if (|region_mask[r]) sel = REG_W'(r);
    end
  end

  assign copy_mask = inj_q ? region_mask[sel] : pend_q;
  assign copy_desc = inj_q ? sel[1] : desc_q;

  mpf_next_hop #(.COLS(COLS), .N(N), .ID_W(ID_W)) u_hop (
    .mask (copy_mask),
    .desc (copy_desc),
    .here (local_id),
    .port (hop_port)
  );

  // next state
  always_comb begin
    pend_en = accept | fire;
    meta_en = accept;
    pend_d  = pend_q;
    dlv_d   = 1'b0;
    if (accept) begin
      if (in_inject) begin
        pend_d = in_dests & ~src_oh;
      end else begin
        pend_d = in_dests & ~local_oh;
        dlv_d  = |(in_dests & local_oh);
      end
    end else if (fire) begin
      pend_d = pend_q & ~copy_mask;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      src_q  <= '0;
      inj_q  <= 1'b0;
      desc_q <= 1'b0;
      dlv_q  <= 1'b0;
    end else begin
      if (pend_en) pend_q <= pend_d;
      if (meta_en) begin
        src_q  <= in_src;
        inj_q  <= in_inject;
        desc_q <= in_desc;
      end
      dlv_q <= dlv_d;
    end
  end

  assign fwd_valid = busy;
  assign fwd_dests = copy_mask;
  assign fwd_desc  = copy_desc;
  assign fwd_port  = hop_port;
  assign fwd_src   = src_q;
  assign dlv_valid = dlv_q;
  assign dlv_src   = src_q;
endmodule

// File: rtl/mpf_fwd_chk.sv
module mpf_fwd_chk #(
  parameter int N    = 64,
  parameter int ID_W = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic [ID_W-1:0] local_id,
  input logic            in_ready,
  input logic            dlv_valid,
  input logic            fwd_valid,
  input logic            fwd_ready,
  input logic [1:0]      fwd_port,
  input logic            fwd_desc,
  input logic [ID_W-1:0] fwd_src,
  input logic [N-1:0]    fwd_dests
);
  // R2: delivery strobe lasts one cycle
  p_dlv_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |=> !dlv_valid);

  // R8: stalled copy holds
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_valid && !fwd_ready) |=> (fwd_valid && $stable(fwd_dests) && $stable(fwd_port)
                                   && $stable(fwd_desc) && $stable(fwd_src)));

  // R3: the local node never travels onward
  p_local_cleared_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> !fwd_dests[local_id]);

  // R4: no empty copy is ever offered
  p_no_empty_copy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> (fwd_dests != '0));

  // R9: no new header while copies are pending
  p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> !in_ready);
endmodule

bind mpf_hdr_fwd mpf_fwd_chk #(.N(N), .ID_W(ID_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .local_id  (local_id),
  .in_ready  (in_ready),
  .dlv_valid (dlv_valid),
  .fwd_valid (fwd_valid),
  .fwd_ready (fwd_ready),
  .fwd_port  (fwd_port),
  .fwd_desc  (fwd_desc),
  .fwd_src   (fwd_src),
  .fwd_dests (fwd_dests)
);

// File: tb/mpf_hdr_fwd_tb.sv
module mpf_hdr_fwd_tb;
  localparam int ROWS = 8;
  localparam int COLS = 8;
  localparam int N    = ROWS * COLS;
  localparam int ID_W = 6;

  logic            clk;
  logic            rst_n;
  logic [ID_W-1:0] local_id;
  logic            in_valid, in_ready, in_inject, in_desc;
  logic [ID_W-1:0] in_src;
  logic [N-1:0]    in_dests;
  logic            dlv_valid;
  logic [ID_W-1:0] dlv_src;
  logic            fwd_valid, fwd_ready, fwd_desc;
  logic [1:0]      fwd_port;
  logic [ID_W-1:0] fwd_src;
  logic [N-1:0]    fwd_dests;

  mpf_hdr_fwd #(.ROWS(ROWS), .COLS(COLS)) u_dut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int total = 0;
  int bad   = 0;
  int ph    = 0;
  logic [63:0] rs = 64'h9E37_79B9_7F4A_7C15;

  logic [N-1:0] e_dests [4];
  bit           e_desc  [4];
  int           e_port  [4];
  int           e_n;
  bit           e_dlv;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] rnd();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 7);
    rs = rs ^ (rs << 17);
    return rs;
  endfunction

  function automatic int lowest(input logic [N-1:0] m);
    for (int i = 0; i < N; i++) if (m[i]) return i;
    return 0;
  endfunction

  function automatic int highest(input logic [N-1:0] m);
    for (int i = N - 1; i >= 0; i--) if (m[i]) return i;
    return 0;
  endfunction

  function automatic int xy_port(input int here, input int tgt);
    if (tgt % COLS > here % COLS) return 0;
    if (tgt % COLS < here % COLS) return 1;
    if (tgt / COLS > here / COLS) return 2;
    return 3;
  endfunction

  function automatic int region_of(input int src, input int a);
    bit up, right;
    up    = a > src;
    right = (a % COLS) >= (src % COLS);
    if (up) return right ? 0 : 1;
    return right ? 2 : 3;
  endfunction

  task automatic plan_inject(input int src, input logic [N-1:0] d);
    e_n   = 0;
    e_dlv = 1'b0;
    for (int r = 0; r < 4; r++) begin
      logic [N-1:0] m;
      int tgt;
      m = '0;
      for (int a = 0; a < N; a++)
        if (a != src && d[a] && region_of(src, a) == r) m[a] = 1'b1;
      if (m != '0) begin
        e_dests[e_n] = m;
        e_desc[e_n]  = (r >= 2);
        tgt = e_desc[e_n] ? highest(m) : lowest(m);
        e_port[e_n]  = xy_port(src, tgt);
        e_n++;
      end
    end
  endtask

  task automatic plan_transit(input int here, input logic [N-1:0] d, input bit desc);
    logic [N-1:0] rem;
    int tgt;
    e_dlv = d[here];
    rem = d;
    rem[here] = 1'b0;
    e_n = (rem != '0) ? 1 : 0;
    e_dests[0] = rem;
    e_desc[0]  = desc;
    tgt = desc ? highest(rem) : lowest(rem);
    e_port[0]  = xy_port(here, tgt);
  endtask

  // called at a negedge with the unit idle
  task automatic run(input bit inj, input bit desc, input int src, input logic [N-1:0] d);
    int k;
    bit stalled;
    logic [N-1:0] h_dests;
    logic [1:0]   h_port;
    logic         h_desc;
    string rq_d;
    rq_d = inj ? "R5" : "R3";
    chk(in_ready == 1'b1, "R9", "ready when idle", 64'(in_ready), 64'd1);
    in_valid  = 1'b1;
    in_inject = inj;
    in_desc   = desc;
    in_src    = ID_W'(src);
    in_dests  = d;
    @(negedge clk);
    in_valid = 1'b0;
    chk(dlv_valid == e_dlv, inj ? "R5" : "R2", "delivery strobe", 64'(dlv_valid), 64'(e_dlv));
    if (e_dlv) chk(dlv_src == ID_W'(src), "R2", "delivered source", 64'(dlv_src), 64'(src));
    k = 0;
    stalled = 1'b0;
    h_dests = '0; h_port = '0; h_desc = 1'b0;
    for (int cyc = 0; cyc < e_n * 3 + 4; cyc++) begin
      bit rdy;
      if (cyc > 0) chk(dlv_valid == 1'b0, "R2", "strobe width", 64'(dlv_valid), 64'd0);
      if (fwd_valid) begin
        chk(in_ready == 1'b0, "R9", "ready while pending", 64'(in_ready), 64'd0);
        if (stalled) begin
          chk(fwd_dests == h_dests && fwd_port == h_port && fwd_desc == h_desc,
              "R8", "stalled copy held", fwd_dests, h_dests);
        end
        if (k >= e_n) begin
          chk(1'b0, rq_d, "extra copy", fwd_dests, 64'd0);
        end else begin
          chk(fwd_dests == e_dests[k], rq_d, "copy bitmap", fwd_dests, e_dests[k]);
          chk(fwd_desc == e_desc[k], "R6", "order flag", 64'(fwd_desc), 64'(e_desc[k]));
          chk(fwd_port == 2'(e_port[k]), "R7", "output port", 64'(fwd_port), 64'(e_port[k]));
          chk(fwd_src == ID_W'(src), rq_d, "copy source", 64'(fwd_src), 64'(src));
        end
        rdy = (ph % 3) != 2;
        ph++;
        fwd_ready = rdy;
        if (rdy) begin
          k++;
          stalled = 1'b0;
        end else begin
          stalled = 1'b1;
          h_dests = fwd_dests; h_port = fwd_port; h_desc = fwd_desc;
        end
      end else begin
        fwd_ready = 1'b1;
        stalled = 1'b0;
      end
      // offer an intruding header only while the unit refuses it
      in_valid  = !in_ready;
      in_inject = 1'b0;
      in_desc   = ~desc;
      in_src    = ~ID_W'(src);
      in_dests  = '1;
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk(k == e_n, (e_n == 0 && !inj) ? "R4" : "R8", "copies consumed", 64'(k), 64'(e_n));
    chk(in_ready == 1'b1 && fwd_valid == 1'b0 && dlv_valid == 1'b0, "R4", "idle after",
        {61'd0, in_ready, fwd_valid, dlv_valid}, 64'd4);
  endtask

  initial begin
    #(8 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    local_id = '0;
    in_valid = 1'b0; in_inject = 1'b0; in_desc = 1'b0;
    in_src = '0; in_dests = '0; fwd_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1 && fwd_valid == 1'b0 && dlv_valid == 1'b0, "R1", "in reset",
        {61'd0, in_ready, fwd_valid, dlv_valid}, 64'd4);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && fwd_valid == 1'b0 && dlv_valid == 1'b0, "R1", "after reset",
        {61'd0, in_ready, fwd_valid, dlv_valid}, 64'd4);

    // transit sweep: every router, four bitmap kinds, both orders
    for (int here = 0; here < N; here++) begin
      local_id = ID_W'(here);
      for (int p = 0; p < 4; p++) begin
        logic [N-1:0] d;
        int src;
        bit desc;
        src  = (here * 7 + 3) % N;
        desc = p[0];
        case (p)
          0: d = rnd();
          1: d = 64'd1 << here;
          2: d = '1;
          default: d = rnd() | (64'd1 << here);
        endcase
        plan_transit(here, d, desc);
        run(1'b0, desc, src, d);
      end
    end

    // empty transit bitmap
    local_id = 6'd9;
    plan_transit(9, '0, 1'b0);
    run(1'b0, 1'b0, 20, '0);

    // injection sweep: every source position
    for (int s = 0; s < N; s++) begin
      local_id = ID_W'(s);
      for (int p = 0; p < 3; p++) begin
        logic [N-1:0] d;
        case (p)
          0: d = rnd();
          1: d = '1;
          default: d = (64'd1 << ((s + 1) % N)) | (64'd1 << s);
        endcase
        plan_inject(s, d);
        run(1'b1, 1'b1, s, d);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule